// File: doc/BRIEF.md
# Processor Bus Release Arbitration Controller

This block sits in a processor's external bus interface. It decides when the processor hands its pins to another bus master or to system logic, and which pin groups it floats when it does. Three request inputs arrive from outside:

- **backoff_req** aborts any running bus cycle and floats every pin group at once.
- **hold_req** waits for the running cycle to finish, then floats every pin group and raises an acknowledge.
- **addr_hold_req** waits for the running cycle to finish, then floats only the address group, so that another agent can drive a snoop address.

The bus-cycle sequencer supplies two status inputs: whether a cycle is running and whether it ends in the current clock. The block returns an abort strobe and a restart pulse to the sequencer. It also gates the sequencer's requests to start new cycles: a request that arrives while the bus is released is held and granted once the bus is regained. A snoop-window output marks the cycles in which the address pins belong to an external driver. It stays low while the processor is in its stop-grant low-power state.

Output enables are active high, with 1 meaning the processor drives the pin. All outputs are registered. A request sampled at one rising edge takes effect at that same edge.

Top module: `bus_release_ctrl`

## Requirements
- R1: While `rst` is high and at the first edge after it, `hold_ack`, `abort_cyc`, `restart_cyc`, `cyc_go` and `snoop_win` are 0, and every bit of `addr_oe`, `data_oe` and `ctrl_oe` is 1.
- R2: If `hold_req` is sampled high while `cyc_active` is 1 and `cyc_last` is 0, then `hold_ack` stays 0 and all enables stay 1. This lasts until the edge at which `cyc_last` (or `cyc_active` = 0) is sampled, and at that edge `hold_ack` rises.
- R3: At the edge where `hold_ack` becomes 1, every bit of `addr_oe`, `data_oe` and `ctrl_oe` becomes 0 in the same edge. The three groups stay 0 for as long as `hold_ack` is 1.
- R4: At the edge where `backoff_req` is sampled high, all three enable groups become 0 and `hold_ack` is 0, whatever the state of the running cycle.
- R5: `abort_cyc` is high for exactly one cycle, after the edge at which `backoff_req` is first sampled high while `cyc_active` is 1.
- R6: With only `addr_hold_req` active, the block drains any running cycle and then clears `addr_oe`. `data_oe` and `ctrl_oe` stay all ones and `hold_ack` stays 0.
- R7: With several requests active, back-off wins over hold, and hold wins over address hold. The enables follow the winning request.
- R8: `snoop_win` is 1 after an edge when the address group is released and `stop_grant` was sampled 0. It is never 1 after an edge at which `stop_grant` was sampled 1.
- R9: The edge that samples all requests low drops `hold_ack` and restores every enable bit to 1.
- R10: After a back-off abort, `restart_cyc` pulses for one cycle at the edge where the block returns to full ownership (all enables 1).
- R11: A `cyc_req` pulse sampled while any release mode or drain is in effect is kept pending. `cyc_go` pulses for one cycle at the edge that restores full ownership. `cyc_go` is never 1 while any enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Full bus release request, waits for the running cycle |
| backoff_req | input | 1 | Immediate release request, aborts the running cycle |
| addr_hold_req | input | 1 | Address-only release for snooping |
| stop_grant | input | 1 | Processor is in the stop-grant low-power state |
| cyc_active | input | 1 | Sequencer has a bus cycle running |
| cyc_last | input | 1 | Running cycle completes in this clock |
| cyc_req | input | 1 | Sequencer asks to begin a new cycle |
| hold_ack | output | 1 | Bus fully released in answer to hold |
| addr_oe | output | ADDR_LANES | Drive enables for the address pins |
| data_oe | output | DATA_LANES | Drive enables for the data byte lanes |
| ctrl_oe | output | CTRL_LANES | Drive enables for strobes and cycle attributes |
| abort_cyc | output | 1 | One-cycle abort strobe to the sequencer |
| restart_cyc | output | 1 | One-cycle pulse: reissue the aborted cycle |
| cyc_go | output | 1 | One-cycle grant to begin a new cycle |
| snoop_win | output | 1 | Address pins are open to an external snoop driver |

## Verification
The hardest case to reach is a back-off that lands on top of an active address hold or hold drain. The bench must then return to ownership through the lower-priority modes without losing the pending restart or the pending cycle request. Random stimulus holds each request level for several cycles, so that releases overlap. Directed sequences stack all three requests and then drop them one at a time. Stop-grant is toggled during a released window, which shows that the snoop indication tracks it from edge to edge.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [2:0] {
        M_OWN        = 3'd0,
        M_DRAIN_HOLD = 3'd1,
        M_DRAIN_ADDR = 3'd2,
        M_REL_HOLD   = 3'd3,
        M_REL_ADDR   = 3'd4,
        M_REL_BOFF   = 3'd5
    } rel_mode_e;

    typedef struct packed {
        logic boff;
        logic hold;
        logic ahold;
    } rel_req_t;

    typedef struct packed {
        logic addr;
        logic data;
        logic ctrl;
    } pin_grp_t;

    // Any mode in which at least one pin group is handed to another agent.
    function automatic logic fn_released(rel_mode_e m);
        return (m == M_REL_HOLD) || (m == M_REL_ADDR) || (m == M_REL_BOFF);
    endfunction

    // Priority: back-off, then hold, then address hold.
    // A released mode never has a cycle running, so it needs no drain.
    function automatic rel_mode_e fn_next_mode(rel_mode_e cur, rel_req_t rq, logic busy);
        rel_mode_e nxt;
        logic      idle_bus;
        idle_bus = fn_released(cur) || !busy;
        if (rq.boff)
            nxt = M_REL_BOFF;
        else if (rq.hold)
            nxt = idle_bus ? M_REL_HOLD : M_DRAIN_HOLD;
        else if (rq.ahold)
            nxt = idle_bus ? M_REL_ADDR : M_DRAIN_ADDR;
        else
            nxt = M_OWN;
        return nxt;
    endfunction

    // Which pin groups the processor drives in a given mode.
    function automatic pin_grp_t fn_drive(rel_mode_e m);
        pin_grp_t g;
        case (m)
            M_REL_ADDR:             g = '{addr: 1'b0, data: 1'b1, ctrl: 1'b1};
            M_REL_HOLD, M_REL_BOFF: g = '{addr: 1'b0, data: 1'b0, ctrl: 1'b0};
            default:                g = '{addr: 1'b1, data: 1'b1, ctrl: 1'b1};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/brc_mode_fsm.sv
module brc_mode_fsm
    import brc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rel_req_t  req,
    input  logic      cyc_active,
    input  logic      cyc_last,
    output rel_mode_e mode,
    output rel_mode_e mode_nxt
);
    logic busy;

    // A cycle still needs the bus unless it is ending in this clock.
    assign busy     = cyc_active && !cyc_last;
    assign mode_nxt = fn_next_mode(mode, req, busy);

    always_ff @(posedge clk) begin
        if (rst)
            mode <= M_OWN;
        else
            mode <= mode_nxt;
    end
endmodule

// File: rtl/brc_pin_enable.sv
module brc_pin_enable
    import brc_pkg::*;
#(
    parameter int ADDR_LANES = 29,
    parameter int DATA_LANES = 8,
    parameter int CTRL_LANES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  rel_mode_e             mode,
    input  rel_mode_e             mode_nxt,
    input  logic                  stop_grant,
    output logic                  hold_ack,
    output logic [ADDR_LANES-1:0] addr_oe,
    output logic [DATA_LANES-1:0] data_oe,
    output logic [CTRL_LANES-1:0] ctrl_oe,
    output logic                  snoop_win
);
    localparam int N_GROUPS = 3;

    pin_grp_t             grp;
    logic [N_GROUPS-1:0]  grp_vec;
    logic                 snoop_q;

    // The decode comes straight from the mode register, so the enables and
    // the acknowledge change on the same edge.
    assign grp      = fn_drive(mode);
    assign grp_vec  = grp;
    assign hold_ack = (mode == M_REL_HOLD);

    // Each group enable fans out to every lane of its pin group.
    for (genvar gi = 0; gi < N_GROUPS; gi++) begin : g_fan
        if (gi == 2) begin : g_addr
            assign addr_oe = {ADDR_LANES{grp_vec[gi]}};
        end else if (gi == 1) begin : g_data
            assign data_oe = {DATA_LANES{grp_vec[gi]}};
        end else begin : g_ctrl
            assign ctrl_oe = {CTRL_LANES{grp_vec[gi]}};
        end
    end

    // The snoop window opens only when the address pins are released and
    // the processor is not in stop-grant.
    always_ff @(posedge clk) begin
        if (rst)
            snoop_q <= 1'b0;
        else
            snoop_q <= fn_released(mode_nxt) && !stop_grant;
    end

    assign snoop_win = snoop_q;
endmodule

// File: rtl/brc_cycle_gate.sv
module brc_cycle_gate
    import brc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      boff_req,
    input  logic      cyc_active,
    input  logic      cyc_req,
    input  rel_mode_e mode,
    input  rel_mode_e mode_nxt,
    output logic      abort_cyc,
    output logic      restart_cyc,
    output logic      cyc_go
);
    logic abort_set;
    logic regain;
    logic rst_pend_q;
    logic go_pend_q;
    logic abort_q;
    logic restart_q;
    logic go_q;

    // An abort is issued once, on entry to back-off, and only if a cycle is running.
    assign abort_set = boff_req && cyc_active && (mode != M_REL_BOFF);
    assign regain    = (mode_nxt == M_OWN);

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_q    <= 1'b0;
            restart_q  <= 1'b0;
            go_q       <= 1'b0;
            rst_pend_q <= 1'b0;
            go_pend_q  <= 1'b0;
        end else begin
            abort_q    <= abort_set;
            restart_q  <= rst_pend_q && regain;
            rst_pend_q <= (rst_pend_q || abort_set) && !regain;
            go_q       <= (cyc_req || go_pend_q) && regain;
            go_pend_q  <= (cyc_req || go_pend_q) && !regain;
        end
    end

    assign abort_cyc   = abort_q;
    assign restart_cyc = restart_q;
    assign cyc_go      = go_q;
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl
    import brc_pkg::*;
#(
    parameter int ADDR_LANES = 29,
    parameter int DATA_LANES = 8,
    parameter int CTRL_LANES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hold_req,
    input  logic                  backoff_req,
    input  logic                  addr_hold_req,
    input  logic                  stop_grant,
    input  logic                  cyc_active,
    input  logic                  cyc_last,
    input  logic                  cyc_req,
    output logic                  hold_ack,
    output logic [ADDR_LANES-1:0] addr_oe,
    output logic [DATA_LANES-1:0] data_oe,
    output logic [CTRL_LANES-1:0] ctrl_oe,
    output logic                  abort_cyc,
    output logic                  restart_cyc,
    output logic                  cyc_go,
    output logic                  snoop_win
);
    rel_req_t  req;
    rel_mode_e mode;
    rel_mode_e mode_nxt;

    assign req = '{boff: backoff_req, hold: hold_req, ahold: addr_hold_req};

    brc_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .cyc_active (cyc_active),
        .cyc_last   (cyc_last),
        .mode       (mode),
        .mode_nxt   (mode_nxt)
    );

    brc_pin_enable #(
        .ADDR_LANES (ADDR_LANES),
        .DATA_LANES (DATA_LANES),
        .CTRL_LANES (CTRL_LANES)
    ) u_pins (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .mode_nxt   (mode_nxt),
        .stop_grant (stop_grant),
        .hold_ack   (hold_ack),
        .addr_oe    (addr_oe),
        .data_oe    (data_oe),
        .ctrl_oe    (ctrl_oe),
        .snoop_win  (snoop_win)
    );

    brc_cycle_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .boff_req    (backoff_req),
        .cyc_active  (cyc_active),
        .cyc_req     (cyc_req),
        .mode        (mode),
        .mode_nxt    (mode_nxt),
        .abort_cyc   (abort_cyc),
        .restart_cyc (restart_cyc),
        .cyc_go      (cyc_go)
    );
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int ADDR_LANES = 29,
    parameter int DATA_LANES = 8,
    parameter int CTRL_LANES = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  hold_req,
    input logic                  backoff_req,
    input logic                  addr_hold_req,
    input logic                  stop_grant,
    input logic                  hold_ack,
    input logic [ADDR_LANES-1:0] addr_oe,
    input logic [DATA_LANES-1:0] data_oe,
    input logic [CTRL_LANES-1:0] ctrl_oe,
    input logic                  abort_cyc,
    input logic                  snoop_win,
    input logic                  cyc_go
);
    // R3
    ack_floats_all_chk: assert property (@(posedge clk) disable iff (rst)
        hold_ack |-> (addr_oe == '0) && (data_oe == '0) && (ctrl_oe == '0));

    // R4
    boff_floats_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(backoff_req) && !$past(rst)) |->
            (addr_oe == '0) && (data_oe == '0) && (ctrl_oe == '0) && !hold_ack);

    // R5
    abort_single_chk: assert property (@(posedge clk) disable iff (rst)
        abort_cyc |=> !abort_cyc);

    // R6
    addr_only_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(addr_hold_req) && !$past(hold_req) && !$past(backoff_req) && !$past(rst)) |->
            !hold_ack && (&data_oe) && (&ctrl_oe));

    // R8
    no_snoop_in_stopgrant_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(stop_grant) && !$past(rst)) |-> !snoop_win);

    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hold_ack) && !$past(hold_req) && !$past(backoff_req) &&
         !$past(addr_hold_req) && !$past(rst)) |-> !hold_ack && (&data_oe) && (&addr_oe));

    // R11
    go_only_when_owned_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_go |-> (&addr_oe) && (&data_oe) && (&ctrl_oe));
endmodule

bind bus_release_ctrl brc_checker #(
    .ADDR_LANES (ADDR_LANES),
    .DATA_LANES (DATA_LANES),
    .CTRL_LANES (CTRL_LANES)
) u_brc_chk (
    .clk           (clk),
    .rst           (rst),
    .hold_req      (hold_req),
    .backoff_req   (backoff_req),
    .addr_hold_req (addr_hold_req),
    .stop_grant    (stop_grant),
    .hold_ack      (hold_ack),
    .addr_oe       (addr_oe),
    .data_oe       (data_oe),
    .ctrl_oe       (ctrl_oe),
    .abort_cyc     (abort_cyc),
    .snoop_win     (snoop_win),
    .cyc_go        (cyc_go)
);

// File: tb/tb_bus_release_ctrl.sv
module tb_bus_release_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AL = 29;
    localparam int DL = 8;
    localparam int CL = 6;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req = 0, backoff_req = 0, addr_hold_req = 0, stop_grant = 0;
    logic cyc_active = 0, cyc_last = 0, cyc_req = 0;
    logic          hold_ack, abort_cyc, restart_cyc, cyc_go, snoop_win;
    logic [AL-1:0] addr_oe;
    logic [DL-1:0] data_oe;
    logic [CL-1:0] ctrl_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model: 0 own, 1 drain hold, 2 drain addr, 3 hold, 4 addr hold, 5 back-off
    int m_s = 0;
    bit m_rpend = 0, m_cpend = 0;
    bit e_abort = 0, e_restart = 0, e_go = 0, e_snoop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_release_ctrl #(.ADDR_LANES(AL), .DATA_LANES(DL), .CTRL_LANES(CL)) dut (
        .clk(clk), .rst(rst), .hold_req(hold_req), .backoff_req(backoff_req),
        .addr_hold_req(addr_hold_req), .stop_grant(stop_grant),
        .cyc_active(cyc_active), .cyc_last(cyc_last), .cyc_req(cyc_req),
        .hold_ack(hold_ack), .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe),
        .abort_cyc(abort_cyc), .restart_cyc(restart_cyc), .cyc_go(cyc_go),
        .snoop_win(snoop_win)
    );

    function automatic int next_state(int s, bit bo, bit hr, bit ah, bit busy);
        bit free;
        free = (s >= 3) || !busy;
        if (bo) return 5;
        if (hr) return free ? 3 : 1;
        if (ah) return free ? 4 : 2;
        return 0;
    endfunction

    function automatic bit exp_addr(int s);  return s <= 2;             endfunction
    function automatic bit exp_dc(int s);    return (s != 3) && (s != 5); endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "hold_ack", int'(hold_ack), int'(m_s == 3));
        chk("R6", "addr_oe", int'(addr_oe), int'({AL{exp_addr(m_s)}}));
        chk("R4", "data_oe", int'(data_oe), int'({DL{exp_dc(m_s)}}));
        chk("R7", "ctrl_oe", int'(ctrl_oe), int'({CL{exp_dc(m_s)}}));
        chk("R5", "abort_cyc", int'(abort_cyc), int'(e_abort));
        chk("R10", "restart_cyc", int'(restart_cyc), int'(e_restart));
        chk("R11", "cyc_go", int'(cyc_go), int'(e_go));
        chk("R8", "snoop_win", int'(snoop_win), int'(e_snoop));
    endtask

    // Advances one clock: predicts from the current inputs, then samples
    // the outputs 1 time unit after the edge.
    task automatic step();
        int  ns;
        bit  busy;
        busy = cyc_active && !cyc_last;
        if (rst) begin
            ns = 0; e_abort = 0; e_restart = 0; e_go = 0; e_snoop = 0;
            m_rpend = 0; m_cpend = 0;
        end else begin
            ns        = next_state(m_s, backoff_req, hold_req, addr_hold_req, busy);
            e_abort   = backoff_req && cyc_active && (m_s != 5);
            e_restart = m_rpend && (ns == 0);
            m_rpend   = (m_rpend || e_abort) && (ns != 0);
            e_go      = (cyc_req || m_cpend) && (ns == 0);
            m_cpend   = (cyc_req || m_cpend) && (ns != 0);
            e_snoop   = (ns >= 3) && !stop_grant;
        end
        m_s = ns;
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic set_req(bit bo, bit hr, bit ah);
        backoff_req = bo; hold_req = hr; addr_hold_req = ah;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        step(); step();
        // R1: reset values
        chk("R1", "reset hold_ack", int'(hold_ack), 0);
        chk("R1", "reset addr_oe", int'(addr_oe), int'({AL{1'b1}}));
        chk("R1", "reset snoop_win", int'(snoop_win), 0);
        rst = 0;
        step();
        chk("R1", "first edge cyc_go", int'(cyc_go), 0);

        // R2: hold during a running cycle waits for its end
        cyc_active = 1; cyc_last = 0; set_req(0, 1, 0);
        step(); step();
        chk("R2", "hold_ack while draining", int'(hold_ack), 0);
        cyc_req = 1; step(); cyc_req = 0;
        cyc_last = 1;
        step();
        chk("R2", "hold_ack at cycle end", int'(hold_ack), 1);
        chk("R3", "data_oe with ack", int'(data_oe), 0);
        cyc_active = 0; cyc_last = 0;
        step();
        // R9: dropping the hold returns the bus on the next edge
        set_req(0, 0, 0);
        step();
        chk("R9", "hold_ack after release", int'(hold_ack), 0);
        chk("R9", "ctrl_oe after release", int'(ctrl_oe), int'({CL{1'b1}}));
        chk("R11", "pending cycle granted", int'(cyc_go), 1);

        // R7: all three requests stacked while a cycle runs
        cyc_active = 1; set_req(1, 1, 1);
        step();
        chk("R7", "back-off wins: hold_ack", int'(hold_ack), 0);
        chk("R5", "abort strobe", int'(abort_cyc), 1);
        cyc_active = 0;
        step();
        chk("R5", "abort lasts one cycle", int'(abort_cyc), 0);
        set_req(0, 1, 1);
        step();
        chk("R7", "hold wins over address hold", int'(hold_ack), 1);
        set_req(0, 0, 1);
        step();
        chk("R6", "address only floated", int'(addr_oe), 0);
        chk("R6", "data still driven", int'(data_oe), int'({DL{1'b1}}));
        chk("R8", "snoop open", int'(snoop_win), 1);
        stop_grant = 1;
        step();
        chk("R8", "snoop closed in stop-grant", int'(snoop_win), 0);
        stop_grant = 0; set_req(0, 0, 0);
        step();
        chk("R10", "restart after abort", int'(restart_cyc), 1);
        step();

        // Random phase with persistent request levels
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) backoff_req   = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 7) == 0) hold_req      = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 5) == 0) addr_hold_req = ($urandom_range(0, 1) == 0);
            if ($urandom_range(0, 9) == 0) stop_grant    = ($urandom_range(0, 3) == 0);
            cyc_active = (m_s <= 2) ? ($urandom_range(0, 9) < 6) : 1'b0;
            cyc_last   = ($urandom_range(0, 9) < 3);
            cyc_req    = ($urandom_range(0, 9) < 2);
            step();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule